// File: doc/BRIEF.md
# Reset Controller with Start-up Timer

This block gathers every reason the chip may need to restart and turns them into a single chip reset. The reasons are a power-up pulse, an active-low master clear pin, a watchdog expiry, and a wake from sleep. Any of them sets a hold latch. The latch is released only by a start-up timer. That timer counts ticks of an internal slow oscillator, and it counts only while master clear is high. If a new reset reason arrives at any point, the timer goes back to zero and the full delay starts again.

Two status flags record what kind of reset took place, so that firmware can read them after the restart. The time-out flag `flag_to` is cleared by a watchdog expiry. The power-down flag `flag_pd` is cleared when the event arrives while the core is asleep. A wake from sleep is always a full reset and never a resume. The number of ticks in the delay is a parameter: a short value suits simulation, and the default of 256 matches an 8-bit counter. The flop reset `arst_n` acts as an extra power-on source. It asserts at once, and its release is synchronised to `clk`.

Top module: `rstc_top`

## Requirements
- R1: While `arst_n` is low, `chip_rst`=1, `flag_to`=1 and `flag_pd`=1. After `arst_n` rises, the block ignores its inputs for two clock edges and responds from the third edge on.
- R2: A `pwr_up` pulse sampled high sets the hold latch and clears the tick count. At the next edge it sets `flag_to`=1 and `flag_pd`=1.
- R3: The tick count advances only on edges where `slow_tick`=1, the latch is held and no reset reason is present. On the edge that takes the DLY_TICKS-th such tick, the latch clears and `chip_rst` falls.
- R4: `chip_rst` is 1 in any cycle where `mclr_n` is 0. A low `mclr_n` clears the tick count, so after it rises a full DLY_TICKS ticks are needed again.
- R5: `wdt_expire`=1 with `asleep`=0 restarts the delay and sets `flag_to`=0 and `flag_pd`=1.
- R6: `wdt_expire`=1 with `asleep`=1 restarts the delay and sets `flag_to`=0 and `flag_pd`=0.
- R7: `mclr_n`=0 with `asleep`=1 sets `flag_to`=1 and `flag_pd`=0.
- R8: `mclr_n`=0 with `asleep`=0 leaves both flags unchanged.
- R9: When sources arrive together, the flags follow the highest one in this order: `pwr_up`, then `wdt_expire`, then master clear.
- R10: When the latch is clear and no reset reason is present, `slow_tick` has no effect: `chip_rst` stays 0 and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low flop reset, treated as power-on |
| pwr_up | input | 1 | Power-up detect pulse |
| mclr_n | input | 1 | Master clear, active low |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| asleep | input | 1 | Core is in sleep state |
| slow_tick | input | 1 | One-cycle tick from the internal slow oscillator |
| chip_rst | output | 1 | Chip reset, active high |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |

## Verification
On every cycle, the assertions check the flag codes that follow each reset reason in both the sleep and the run state. They also check that master clear always leads to reset, and that reset never ends except on an edge that took a slow tick.

Some properties depend on history across many cycles, and only the bench scenarios can show them. These are the exact release edge after DLY_TICKS ticks, the restart of the count when a source interrupts a delay that is already running, the priority order when sources coincide, and the two-edge reset release. A behavioural model checks all three outputs on every clock.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef struct packed {
    logic to;
    logic pd;
  } rstc_flags_t;

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_POWER,
    CAUSE_WDT_RUN,
    CAUSE_WDT_WAKE,
    CAUSE_MCLR_WAKE
  } rstc_cause_e;

  function automatic rstc_flags_t flags_of(rstc_cause_e c);
    rstc_flags_t f;
    case (c)
      CAUSE_WDT_RUN:   f = '{to: 1'b0, pd: 1'b1};
      CAUSE_WDT_WAKE:  f = '{to: 1'b0, pd: 1'b0};
      CAUSE_MCLR_WAKE: f = '{to: 1'b1, pd: 1'b0};
      default:         f = '{to: 1'b1, pd: 1'b1};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/rstc_delay.sv
module rstc_delay #(
  parameter int DLY_TICKS = 256
) (
  input  logic clk,
  input  logic srst_n,
  input  logic restart,
  input  logic tick,
  output logic hold
);
  localparam int CW = (DLY_TICKS > 1) ? $clog2(DLY_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY_TICKS - 1);

  logic          hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv_en;

  assign adv_en = hold_q && tick && !restart;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (restart) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (adv_en) begin
      if (cnt_q == LAST) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic        clk,
  input  logic        srst_n,
  input  logic        pwr_up,
  input  logic        mclr_n,
  input  logic        wdt_expire,
  input  logic        asleep,
  output rstc_flags_t flags
);
  rstc_cause_e cause;
  rstc_flags_t flags_q, flags_d;

  always_comb begin
    if (pwr_up)                cause = CAUSE_POWER;
    else if (wdt_expire)       cause = asleep ? CAUSE_WDT_WAKE : CAUSE_WDT_RUN;
    else if (!mclr_n && asleep) cause = CAUSE_MCLR_WAKE;
    else                       cause = CAUSE_NONE;
  end

  always_comb begin
    flags_d = flags_q;
    if (cause != CAUSE_NONE) flags_d = flags_of(cause);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) flags_q <= '{to: 1'b1, pd: 1'b1};
    else         flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int DLY_TICKS = 256
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pwr_up,
  input  logic mclr_n,
  input  logic wdt_expire,
  input  logic asleep,
  input  logic slow_tick,
  output logic chip_rst,
  output logic flag_to,
  output logic flag_pd
);
  logic        srst_n;
  logic        hold;
  logic        restart;
  rstc_flags_t flags;

  assign restart = pwr_up | ~mclr_n | wdt_expire;

  rstc_sync u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  rstc_delay #(.DLY_TICKS(DLY_TICKS)) u_delay (
    .clk     (clk),
    .srst_n  (srst_n),
    .restart (restart),
    .tick    (slow_tick),
    .hold    (hold)
  );

  rstc_cause u_cause (
    .clk        (clk),
    .srst_n     (srst_n),
    .pwr_up     (pwr_up),
    .mclr_n     (mclr_n),
    .wdt_expire (wdt_expire),
    .asleep     (asleep),
    .flags      (flags)
  );

  assign chip_rst = hold | ~mclr_n;
  assign flag_to  = flags.to;
  assign flag_pd  = flags.pd;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk (
  input logic clk,
  input logic srst_n,
  input logic pwr_up,
  input logic mclr_n,
  input logic wdt_expire,
  input logic asleep,
  input logic slow_tick,
  input logic chip_rst,
  input logic flag_to,
  input logic flag_pd
);
  assert_pwrup_flags_R2: assert property (@(posedge clk) disable iff (!srst_n)
    pwr_up |=> (flag_to && flag_pd));

  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(chip_rst) |-> $past(slow_tick));

  assert_mclr_holds_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !mclr_n |=> chip_rst);

  assert_wdt_run_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (wdt_expire && !pwr_up && !asleep) |=> (!flag_to && flag_pd && chip_rst));

  assert_wdt_wake_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (wdt_expire && !pwr_up && asleep) |=> (!flag_to && !flag_pd && chip_rst));

  assert_mclr_wake_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (!mclr_n && asleep && !pwr_up && !wdt_expire) |=> (flag_to && !flag_pd));

  assert_mclr_run_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (!mclr_n && !asleep && !pwr_up && !wdt_expire) |=> ($stable(flag_to) && $stable(flag_pd)));
endmodule

bind rstc_top rstc_chk u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .pwr_up     (pwr_up),
  .mclr_n     (mclr_n),
  .wdt_expire (wdt_expire),
  .asleep     (asleep),
  .slow_tick  (slow_tick),
  .chip_rst   (chip_rst),
  .flag_to    (flag_to),
  .flag_pd    (flag_pd)
);

// File: tb/sim_rstc_top.sv
module sim_rstc_top;
  localparam int D = 5;

  logic clk = 1'b0;
  logic arst_n, pwr_up, mclr_n, wdt_expire, asleep, slow_tick;
  logic chip_rst, flag_to, flag_pd;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_hold = 1'b1;
  int m_cnt  = 0;
  bit m_to   = 1'b1;
  bit m_pd   = 1'b1;
  int m_rel  = 0;

  always #10 clk = ~clk;

  rstc_top #(.DLY_TICKS(D)) u0 (
    .clk(clk), .arst_n(arst_n), .pwr_up(pwr_up), .mclr_n(mclr_n),
    .wdt_expire(wdt_expire), .asleep(asleep), .slow_tick(slow_tick),
    .chip_rst(chip_rst), .flag_to(flag_to), .flag_pd(flag_pd)
  );

  always @(posedge clk) begin
    if (!arst_n) begin
      m_hold = 1; m_cnt = 0; m_to = 1; m_pd = 1; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      if (pwr_up) begin m_to = 1; m_pd = 1; end
      else if (wdt_expire) begin m_to = 0; m_pd = !asleep; end
      else if (!mclr_n && asleep) begin m_to = 1; m_pd = 0; end
      if (pwr_up || !mclr_n || wdt_expire) begin
        m_hold = 1; m_cnt = 0;
      end else if (m_hold && slow_tick) begin
        m_cnt++;
        if (m_cnt == D) begin m_hold = 0; m_cnt = 0; end
      end
    end
  end

  task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
      expect_bit(cur_req, "model chip_rst", chip_rst, m_hold || !mclr_n);
      expect_bit(cur_req, "model flag_to", flag_to, m_to);
      expect_bit(cur_req, "model flag_pd", flag_pd, m_pd);
    end
  endtask

  task automatic expect_out(input string req, input logic r, input logic t, input logic p);
    expect_bit(req, "chip_rst", chip_rst, r);
    expect_bit(req, "flag_to", flag_to, t);
    expect_bit(req, "flag_pd", flag_pd, p);
  endtask

  initial begin
    arst_n = 0; pwr_up = 0; mclr_n = 1; wdt_expire = 0; asleep = 0; slow_tick = 0;
    cur_req = "R1"; cyc(3);
    expect_out("R1", 1, 1, 1);
    arst_n = 1; slow_tick = 1;
    cur_req = "R3"; cyc(6);
    expect_out("R3", 1, 1, 1);
    cyc(1);
    expect_out("R3", 0, 1, 1);
    cur_req = "R10"; cyc(4);
    expect_out("R10", 0, 1, 1);
    cur_req = "R5"; wdt_expire = 1; cyc(1); wdt_expire = 0;
    expect_out("R5", 1, 0, 1);
    cyc(4); expect_out("R5", 1, 0, 1);
    cyc(1); expect_out("R5", 0, 0, 1);
    cur_req = "R6"; wdt_expire = 1; asleep = 1; cyc(1); wdt_expire = 0; asleep = 0;
    expect_out("R6", 1, 0, 0);
    cyc(5); expect_out("R6", 0, 0, 0);
    cur_req = "R8"; mclr_n = 0; cyc(1);
    expect_out("R8", 1, 0, 0);
    cur_req = "R4"; cyc(6);
    expect_out("R4", 1, 0, 0);
    mclr_n = 1; cyc(4);
    expect_out("R4", 1, 0, 0);
    cyc(1); expect_out("R4", 0, 0, 0);
    cur_req = "R7"; asleep = 1; mclr_n = 0; cyc(2); mclr_n = 1; asleep = 0;
    expect_out("R7", 1, 1, 0);
    cyc(5); expect_out("R7", 0, 1, 0);
    cur_req = "R9"; pwr_up = 1; wdt_expire = 1; asleep = 1; cyc(1);
    pwr_up = 0; wdt_expire = 0; asleep = 0;
    expect_out("R9", 1, 1, 1);
    wdt_expire = 1; mclr_n = 0; asleep = 1; cyc(1);
    wdt_expire = 0; mclr_n = 1; asleep = 0;
    expect_out("R9", 1, 0, 0);
    cur_req = "R2"; cyc(2);
    pwr_up = 1; cyc(1); pwr_up = 0;
    expect_out("R2", 1, 1, 1);
    cyc(4); expect_out("R2", 1, 1, 1);
    cyc(1); expect_out("R2", 0, 1, 1);
    cur_req = "R3"; wdt_expire = 1; cyc(1); wdt_expire = 0;
    for (int k = 0; k < 14; k++) begin
      slow_tick = k[0];
      cyc(1);
    end
    slow_tick = 0;
    cur_req = "R10"; cyc(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule